// File: doc/BRIEF.md
# Training-Set Run Qualifier

This block sits behind the symbol decoder of one lane while the link is in recovery. For every training ordered set that arrives it decides whether the set continues the current run of consecutive, qualifying sets. When the run reaches the required length it produces a one-cycle advance pulse, which the state machine above uses to leave the lock substate. Sets of either training type count toward the same run. Two sets are consecutive only when their comparison symbols 6 to 9 match.

Sets must carry the link and lane numbers that this side transmits, and the received link number must lie in the legal range. A wrong set breaks the run and raises a sticky mismatch flag. While the equalization substate is flagged, the numbers are not compared at all. A full run whose sets all request a speed change raises the directed-speed-change flag and does not advance. The run then starts over, so a second full run is needed before the advance. A cycle-count timer is armed at substate entry. If it expires before any advance, it raises a sticky timeout flag and the block stops qualifying sets.

A one-cycle `start_i` marks entry to the substate and clears every counter and flag. Until the first start, received sets are ignored.

Top module: `ts_consec_qualifier`

## Requirements
- R1: After a start, `advance_o` is high for exactly one cycle, in the cycle after the clock edge that accepts the RUN_TARGET-th (default 8) consecutive qualifying set. Type-1 and type-2 sets (`ts_is_ts2_i` low or high) count equally, in any mix.
- R2: A qualifying set whose symbols 6 to 9 (`rx_sym69_i`) differ from those of the previous qualifying set does not extend the run. It restarts the count at 1 and becomes the new reference.
- R3: When `eq_mode_i` is low, a set whose received link number differs from `tx_link_i`, or whose lane number differs from `tx_lane_i`, clears the run to 0 and sets `mismatch_o`. When `eq_mode_i` is high, link and lane numbers are not compared.
- R4: A received link number above MAX_LINK (default 31) is a mismatch, even when it equals `tx_link_i`.
- R5: The speed-change bit is part of the run reference. A qualifying set whose speed-change bit differs from that of the previous set restarts the count at 1.
- R6: When a full run of sets with the speed-change bit set completes while `dir_speed_chg_o` is low, `dir_speed_chg_o` rises in the next cycle and no advance is given. The count is then cleared, so a further full run with the bit set is needed before `advance_o` pulses.
- R7: If no advance has occurred, `timeout_o` rises exactly TIMEOUT_CYCLES cycles after the edge that accepts `start_i`. After a timeout no advance is given, and after an advance no timeout is raised.
- R8: `start_i` clears the run, `mismatch_o`, `dir_speed_chg_o` and `timeout_o`. Sets received before the first start, or after an advance until the next start, have no effect on the outputs.
- R9: While `rst_n` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Substate entry; clears all state and arms the timer |
| eq_mode_i | input | 1 | Equalization substate; disables link/lane comparison |
| ts_valid_i | input | 1 | One decoded training set is present this cycle |
| ts_is_ts2_i | input | 1 | Set type: 0 type-1, 1 type-2 |
| rx_link_i | input | 8 | Received link number |
| rx_lane_i | input | 8 | Received lane number |
| rx_sym69_i | input | 32 | Received symbols 6 to 9 |
| rx_speed_chg_i | input | 1 | Received speed-change bit |
| tx_link_i | input | 8 | Link number this side transmits |
| tx_lane_i | input | 8 | Lane number this side transmits |
| advance_o | output | 1 | One-cycle pulse: run complete, move on |
| dir_speed_chg_o | output | 1 | Sticky: speed change has been directed |
| mismatch_o | output | 1 | Sticky: a set with wrong numbers was seen |
| timeout_o | output | 1 | Sticky: timer expired without an advance |

## Verification
On every cycle, the assertions check several properties. The run count never reaches the target without being consumed. A numbers mismatch empties the run on the next cycle. The advance is a single-cycle pulse that follows an accepted set. Advance and timeout never coexist, and the sticky flags hold until the next start. The exact run lengths can only be shown by the bench's directed scenarios: restarts on a changed symbol field or speed-change bit, the doubled run after a directed speed change, the out-of-range link number, the equalization bypass and the precise cycle of timer expiry.

// File: rtl/ts_qual_pkg.sv
package ts_qual_pkg;
  localparam int TS_NUM_W = 8;
  localparam int TS_SYM_W = 32;

  typedef logic [TS_NUM_W-1:0] ts_num_t;
  typedef logic [TS_SYM_W-1:0] ts_sym_t;

  // Reference kept for the consecutive comparison
  typedef struct packed {
    logic    vld;
    logic    spd;
    ts_sym_t sym;
  } ts_ref_t;
endpackage

// File: rtl/ts_num_check.sv
module ts_num_check
  import ts_qual_pkg::*;
#(
  parameter int MAX_LINK = 31
) (
  input  ts_num_t rx_link_i,
  input  ts_num_t rx_lane_i,
  input  ts_num_t tx_link_i,
  input  ts_num_t tx_lane_i,
  input  logic    eq_mode_i,
  output logic    nums_ok_o
);
  localparam ts_num_t LINK_LIMIT = ts_num_t'(MAX_LINK);

  logic link_in_range;
  logic link_same;
  logic lane_same;

  always_comb begin
    link_in_range = (rx_link_i <= LINK_LIMIT);
    link_same     = (rx_link_i == tx_link_i);
    lane_same     = (rx_lane_i == tx_lane_i);
    // During equalization the numbers are not part of qualification
    nums_ok_o     = eq_mode_i | (link_in_range & link_same & lane_same);
  end
endmodule

// File: rtl/ts_run_tracker.sv
module ts_run_tracker
  import ts_qual_pkg::*;
#(
  parameter int RUN_TARGET = 8
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start_i,
  input  logic    set_vld_i,
  input  logic    nums_ok_i,
  input  ts_sym_t sym_i,
  input  logic    spd_i,
  input  logic    expired_i,
  output logic    adv_next_o,
  output logic    advance_o,
  output logic    dsc_o,
  output logic    mism_o
);
  localparam int CNT_W = $clog2(RUN_TARGET + 1);
  localparam logic [CNT_W-1:0] TARGET = CNT_W'(RUN_TARGET);

  logic             armed_q, armed_d;
  logic             done_q, done_d;
  logic             dsc_q, dsc_d;
  logic             mism_q, mism_d;
  logic             adv_q, adv_d;
  logic [CNT_W-1:0] run_q, run_d;
  ts_ref_t          ref_q, ref_d;
  logic             ref_en;

  logic             take;
  logic             cont;
  logic [CNT_W-1:0] run_inc;

  always_comb begin
    armed_d = armed_q;
    done_d  = done_q;
    dsc_d   = dsc_q;
    mism_d  = mism_q;
    run_d   = run_q;
    ref_d   = ref_q;
    ref_en  = 1'b0;
    adv_d   = 1'b0;
    take    = armed_q & ~done_q & ~expired_i & set_vld_i;
    cont    = ref_q.vld & (ref_q.sym == sym_i) & (ref_q.spd == spd_i);
    run_inc = cont ? (run_q + CNT_W'(1)) : CNT_W'(1);

    if (start_i) begin
      armed_d = 1'b1;
      done_d  = 1'b0;
      dsc_d   = 1'b0;
      mism_d  = 1'b0;
      run_d   = '0;
      ref_d   = '0;
      ref_en  = 1'b1;
    end else if (take) begin
      ref_en = 1'b1;
      if (!nums_ok_i) begin
        mism_d = 1'b1;
        run_d  = '0;
        ref_d  = '0;
      end else begin
        ref_d.vld = 1'b1;
        ref_d.spd = spd_i;
        ref_d.sym = sym_i;
        if (run_inc == TARGET) begin
          run_d     = '0;
          if (spd_i && !dsc_q) begin
            // Speed change directed: demand a fresh full run
            dsc_d     = 1'b1;
            ref_d.vld = 1'b0;
          end else begin
            adv_d  = 1'b1;
            done_d = 1'b1;
          end
        end else begin
          run_d = run_inc;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      done_q  <= 1'b0;
      dsc_q   <= 1'b0;
      mism_q  <= 1'b0;
      adv_q   <= 1'b0;
      run_q   <= '0;
    end else begin
      armed_q <= armed_d;
      done_q  <= done_d;
      dsc_q   <= dsc_d;
      mism_q  <= mism_d;
      adv_q   <= adv_d;
      run_q   <= run_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0;
    end else if (ref_en) begin
      ref_q <= ref_d;
    end
  end

  assign adv_next_o = adv_d;
  assign advance_o  = adv_q;
  assign dsc_o      = dsc_q;
  assign mism_o     = mism_q;

  AST_RUN_BELOW_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    run_q < TARGET); // R2
  AST_MISMATCH_EMPTIES_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && armed_q && !done_q && !expired_i && set_vld_i && !nums_ok_i)
      |=> (run_q == '0 && mism_q)); // R3
  AST_ADV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    advance_o |=> !advance_o); // R1
  AST_ADV_AFTER_SET: assert property (@(posedge clk) disable iff (!rst_n)
    advance_o |-> $past(set_vld_i && nums_ok_i)); // R1
  AST_DSC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (dsc_q && !start_i) |=> dsc_q); // R6
endmodule

// File: rtl/ts_expiry_timer.sv
module ts_expiry_timer #(
  parameter int TIMEOUT_CYCLES = 6000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  output logic expired_o
);
  localparam int TW = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam logic [TW-1:0] LAST = TW'(TIMEOUT_CYCLES - 1);

  logic          run_q, run_d;
  logic          exp_q, exp_d;
  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    run_d  = run_q;
    exp_d  = exp_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (start_i) begin
      run_d  = 1'b1;
      exp_d  = 1'b0;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (run_q) begin
      if (stop_i) begin
        run_d = 1'b0;
      end else if (cnt_q == LAST) begin
        run_d = 1'b0;
        exp_d = 1'b1;
      end else begin
        cnt_d  = cnt_q + TW'(1);
        cnt_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      exp_q <= 1'b0;
    end else begin
      run_q <= run_d;
      exp_q <= exp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired_o = exp_q;

  AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (expired_o && !start_i) |=> expired_o); // R7
  AST_TIMEOUT_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expired_o) |-> $past(run_q && !stop_i)); // R7
endmodule

// File: rtl/ts_consec_qualifier.sv
module ts_consec_qualifier
  import ts_qual_pkg::*;
#(
  parameter int RUN_TARGET     = 8,
  parameter int MAX_LINK       = 31,
  parameter int TIMEOUT_CYCLES = 6000000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        eq_mode_i,
  input  logic        ts_valid_i,
  input  logic        ts_is_ts2_i,
  input  logic [7:0]  rx_link_i,
  input  logic [7:0]  rx_lane_i,
  input  logic [31:0] rx_sym69_i,
  input  logic        rx_speed_chg_i,
  input  logic [7:0]  tx_link_i,
  input  logic [7:0]  tx_lane_i,
  output logic        advance_o,
  output logic        dir_speed_chg_o,
  output logic        mismatch_o,
  output logic        timeout_o
);
  logic nums_ok;
  logic adv_next;
  logic expired;

  ts_num_check #(.MAX_LINK(MAX_LINK)) u_num (
    .rx_link_i (rx_link_i),
    .rx_lane_i (rx_lane_i),
    .tx_link_i (tx_link_i),
    .tx_lane_i (tx_lane_i),
    .eq_mode_i (eq_mode_i),
    .nums_ok_o (nums_ok)
  );

  ts_run_tracker #(.RUN_TARGET(RUN_TARGET)) u_run (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .set_vld_i  (ts_valid_i),
    .nums_ok_i  (nums_ok),
    .sym_i      (rx_sym69_i),
    .spd_i      (rx_speed_chg_i),
    .expired_i  (expired),
    .adv_next_o (adv_next),
    .advance_o  (advance_o),
    .dsc_o      (dir_speed_chg_o),
    .mism_o     (mismatch_o)
  );

  ts_expiry_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .stop_i    (adv_next),
    .expired_o (expired)
  );

  assign timeout_o = expired;

  AST_ADV_EXCLUDES_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    advance_o |-> !timeout_o); // R7
  AST_TYPE_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    ts_valid_i |-> !$isunknown(ts_is_ts2_i)); // R1
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!advance_o && !mismatch_o && !dir_speed_chg_o && !timeout_o)); // R8
endmodule

// File: tb/ts_consec_qualifier_tb.sv
module ts_consec_qualifier_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 300;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, eq_mode_i, ts_valid_i, ts_is_ts2_i, rx_speed_chg_i;
  logic [7:0]  rx_link_i, rx_lane_i, tx_link_i, tx_lane_i;
  logic [31:0] rx_sym69_i;
  logic        advance_o, dir_speed_chg_o, mismatch_o, timeout_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ts_consec_qualifier #(.RUN_TARGET(8), .MAX_LINK(31), .TIMEOUT_CYCLES(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .eq_mode_i(eq_mode_i),
    .ts_valid_i(ts_valid_i), .ts_is_ts2_i(ts_is_ts2_i), .rx_link_i(rx_link_i),
    .rx_lane_i(rx_lane_i), .rx_sym69_i(rx_sym69_i), .rx_speed_chg_i(rx_speed_chg_i),
    .tx_link_i(tx_link_i), .tx_lane_i(tx_lane_i), .advance_o(advance_o),
    .dir_speed_chg_o(dir_speed_chg_o), .mismatch_o(mismatch_o), .timeout_o(timeout_o)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // All drive tasks start and end on a falling edge
  task automatic do_start(input logic eq);
    eq_mode_i = eq;
    start_i   = 1'b1;
    @(negedge clk);
    start_i   = 1'b0;
  endtask

  task automatic send(input logic t2, input logic [7:0] lk, input logic [7:0] ln,
                      input logic [31:0] sym, input logic spd);
    ts_valid_i     = 1'b1;
    ts_is_ts2_i    = t2;
    rx_link_i      = lk;
    rx_lane_i      = ln;
    rx_sym69_i     = sym;
    rx_speed_chg_i = spd;
    @(negedge clk);
    ts_valid_i     = 1'b0;
  endtask

  task automatic send_good(input int n, input logic [31:0] sym, input logic spd);
    for (int i = 0; i < n; i++) send(i[0], tx_link_i, tx_lane_i, sym, spd);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; start_i = 0; eq_mode_i = 0; ts_valid_i = 0; ts_is_ts2_i = 0;
    rx_link_i = 8'd3; rx_lane_i = 8'd1; tx_link_i = 8'd3; tx_lane_i = 8'd1;
    rx_sym69_i = 32'h0; rx_speed_chg_i = 0;
    repeat (3) @(negedge clk);
    chk("R9", "advance", advance_o, 0);
    chk("R9", "dsc", dir_speed_chg_o, 0);
    chk("R9", "mismatch", mismatch_o, 0);
    chk("R9", "timeout", timeout_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    send_good(8, 32'h4A4A4A4A, 0);
    chk("R8", "no advance before start", advance_o, 0);
  endtask

  task automatic t_mix;
    do_start(0);
    for (int i = 0; i < 7; i++) begin
      send(i[0], tx_link_i, tx_lane_i, 32'h11223344, 0);
      chk("R1", "no advance before 8", advance_o, 0);
    end
    send(1, tx_link_i, tx_lane_i, 32'h11223344, 0);
    chk("R1", "advance on 8th mixed", advance_o, 1);
    @(negedge clk);
    chk("R1", "advance one cycle", advance_o, 0);
    send_good(8, 32'h11223344, 0);
    chk("R8", "no second advance", advance_o, 0);
  endtask

  task automatic t_sym;
    do_start(0);
    send_good(5, 32'hAAAA0001, 0);
    send_good(7, 32'hBBBB0002, 0);
    chk("R2", "sym change restarts", advance_o, 0);
    send_good(1, 32'hBBBB0002, 0);
    chk("R2", "advance after new ref run", advance_o, 1);
  endtask

  task automatic t_num;
    do_start(0);
    send_good(4, 32'h5, 0);
    send(0, tx_link_i, tx_lane_i + 8'd1, 32'h5, 0);
    chk("R3", "lane mismatch flag", mismatch_o, 1);
    send_good(7, 32'h5, 0);
    chk("R3", "run cleared by mismatch", advance_o, 0);
    send_good(1, 32'h5, 0);
    chk("R3", "advance after clean run", advance_o, 1);
    do_start(0);
    send(0, tx_link_i + 8'd2, tx_lane_i, 32'h5, 0);
    chk("R3", "link mismatch flag", mismatch_o, 1);
    do_start(1);
    for (int i = 0; i < 8; i++) send(i[0], 8'd77, 8'd9, 32'h6, 0);
    chk("R3", "eq mode ignores numbers", advance_o, 1);
    chk("R3", "eq mode no mismatch", mismatch_o, 0);
    eq_mode_i = 0;
  endtask

  task automatic t_range;
    tx_link_i = 8'd40;
    do_start(0);
    send(0, 8'd40, tx_lane_i, 32'h7, 0);
    chk("R4", "link above 31 mismatches", mismatch_o, 1);
    tx_link_i = 8'd31;
    do_start(0);
    send_good(8, 32'h7, 0);
    chk("R4", "link 31 accepted", mismatch_o, 0);
    chk("R4", "link 31 advances", advance_o, 1);
    tx_link_i = 8'd3;
  endtask

  task automatic t_spd;
    do_start(0);
    send_good(7, 32'h9, 1);
    chk("R6", "dsc not yet", dir_speed_chg_o, 0);
    send_good(1, 32'h9, 1);
    chk("R6", "dsc raised", dir_speed_chg_o, 1);
    chk("R6", "no advance on dsc run", advance_o, 0);
    send_good(7, 32'h9, 1);
    chk("R6", "count was cleared", advance_o, 0);
    send_good(1, 32'h9, 1);
    chk("R6", "advance after second run", advance_o, 1);
    do_start(0);
    chk("R8", "start clears dsc", dir_speed_chg_o, 0);
    send_good(4, 32'h9, 0);
    send_good(4, 32'h9, 1);
    chk("R5", "spd bit change restarts", advance_o, 0);
    chk("R5", "no dsc after split run", dir_speed_chg_o, 0);
    send_good(4, 32'h9, 1);
    chk("R5", "dsc after 8 spd sets", dir_speed_chg_o, 1);
  endtask

  task automatic t_timeout;
    do_start(0);
    send(0, tx_link_i, 8'd99, 32'h1, 0);
    repeat (TMO - 2) @(negedge clk);
    chk("R7", "no timeout early", timeout_o, 0);
    @(negedge clk);
    chk("R7", "timeout at limit", timeout_o, 1);
    send_good(8, 32'h2, 0);
    chk("R7", "no advance after timeout", advance_o, 0);
    do_start(0);
    chk("R8", "start clears timeout", timeout_o, 0);
    chk("R8", "start clears mismatch", mismatch_o, 0);
    send_good(8, 32'h3, 0);
    chk("R7", "advance before timer", advance_o, 1);
    repeat (TMO + 20) @(negedge clk);
    chk("R7", "no timeout after advance", timeout_o, 0);
  endtask

  initial begin
    t_reset();
    t_mix();
    t_sym();
    t_num();
    t_range();
    t_spd();
    t_timeout();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule